// File: doc/BRIEF.md
# Selectable-Operand Arithmetic Unit

This block is a combinational arithmetic unit of parameterised width. It is a ripple chain of full-adder slices. Every slice adds its bit of operand A to a second operand bit. A two-bit operand selector forms that second bit from B. It can give zero, B itself, the inverse of B, or a constant one, so the second operand is 0, B, ~B or all-ones across the word.

An external carry enters the lowest slice. The selector and the carry together give eight functions:

| Selector | Carry in | Function |
|---|---|---|
| 00 | 0 | transfer A |
| 00 | 1 | increment A |
| 01 | 0 | A + B |
| 01 | 1 | A + B + 1 |
| 10 | 0 | A − B − 1 |
| 10 | 1 | A − B |
| 11 | 0 | decrement A |
| 11 | 1 | transfer A with carry set |

The block drives the sum, the carry out of the top slice, and a signed-overflow flag. It has no clock or reset. Every output follows its inputs in the same cycle.

Top module: `arith_unit`

## Requirements
- R1: With op_sel = 2'b00 and carry_in = 0, result equals a and carry_out is 0.
- R2: With op_sel = 2'b00 and carry_in = 1, result equals a + 1 modulo 2^N. carry_out is 1 only when a is all-ones.
- R3: With op_sel = 2'b01, {carry_out, result} equals a + b + carry_in as an N+1-bit unsigned sum.
- R4: With op_sel = 2'b10, {carry_out, result} equals a + (~b) + carry_in. With carry_in = 1 this is a − b in two's complement, and carry_out is 1 exactly when a >= b unsigned.
- R5: With op_sel = 2'b11 and carry_in = 0, result equals a − 1 modulo 2^N. carry_out is 0 only when a is zero.
- R6: With op_sel = 2'b11 and carry_in = 1, result equals a and carry_out is 1.
- R7: overflow is 1 exactly when the signed sum of a, the selected second operand and carry_in falls outside the signed range of N bits.
- R8: All outputs are combinational functions of the present inputs, and are valid in the same cycle the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | N | First operand, fed unchanged to every slice |
| b | input | N | Source of the second operand |
| op_sel | input | 2 | Second-operand select: 00 zero, 01 b, 10 ~b, 11 all-ones |
| carry_in | input | 1 | Carry into the least significant slice |
| result | output | N | Sum word |
| carry_out | output | 1 | Carry leaving the most significant slice |
| overflow | output | 1 | Signed overflow of the sum |

## Verification
No result has any latency: the sum, carry and overflow are due in the cycle the operands and select change. The bench drives every new input set shortly after a rising edge. It compares the outputs against its arithmetic model at the next falling edge, so the ripple chain has half a period to settle. No check ever looks at a value left over from an earlier vector.

// File: rtl/arith_pkg.sv
package arith_pkg;
  typedef enum logic [1:0] {
    YSEL_ZERO = 2'b00,
    YSEL_PASS = 2'b01,
    YSEL_INV  = 2'b10,
    YSEL_ONES = 2'b11
  } ysel_e;
endpackage

// File: rtl/yop_mux.sv
module yop_mux
  import arith_pkg::*;
(
  input  ysel_e sel,
  input  logic  b_bit,
  output logic  y_bit
);
  always_comb begin
    unique case (sel)
      YSEL_ZERO: y_bit = 1'b0;
      YSEL_PASS: y_bit = b_bit;
      YSEL_INV:  y_bit = ~b_bit;
      YSEL_ONES: y_bit = 1'b1;
      default:   y_bit = 1'b0;
    endcase
  end
endmodule

// File: rtl/fa_cell.sv
module fa_cell (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  logic half;
  always_comb begin
    half = x ^ y;
    s    = half ^ ci;
    co   = (x & y) | (half & ci);
  end
endmodule

// File: rtl/ripple_chain.sv
module ripple_chain #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_into_top,
  output logic         cout
);
  logic [W:0] carry;

  assign carry[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_slice
    fa_cell u_fa (
      .x  (x[i]),
      .y  (y[i]),
      .ci (carry[i]),
      .s  (sum[i]),
      .co (carry[i+1])
    );
  end

  assign c_into_top = carry[W-1];
  assign cout       = carry[W];
endmodule

// File: rtl/arith_unit.sv
module arith_unit
  import arith_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic [1:0]   op_sel,
  input  logic         carry_in,
  output logic [N-1:0] result,
  output logic         carry_out,
  output logic         overflow
);
  localparam int MSB = N - 1;

  ysel_e        sel_q;
  logic [N-1:0] y_word;
  logic         c_msb_in;
  logic         c_msb_out;

  assign sel_q = ysel_e'(op_sel);

  for (genvar i = 0; i < N; i++) begin : g_ysel
    yop_mux u_mux (
      .sel   (sel_q),
      .b_bit (b[i]),
      .y_bit (y_word[i])
    );
  end

  ripple_chain #(.W(N)) u_chain (
    .x          (a),
    .y          (y_word),
    .cin        (carry_in),
    .sum        (result),
    .c_into_top (c_msb_in),
    .cout       (c_msb_out)
  );

  assign carry_out = c_msb_out;
  assign overflow  = c_msb_in ^ c_msb_out;

  logic unused_msb;
  assign unused_msb = (MSB >= 0);
endmodule

// File: rtl/arith_unit_chk.sv
module arith_unit_chk #(
  parameter int N = 8
) (
  input logic [N-1:0] a,
  input logic [N-1:0] b,
  input logic [1:0]   op_sel,
  input logic         carry_in,
  input logic [N-1:0] result,
  input logic         carry_out,
  input logic         overflow
);
  logic op_msb;

  always_comb begin
    case (op_sel)
      2'b00:   op_msb = 1'b0;
      2'b01:   op_msb = b[N-1];
      2'b10:   op_msb = ~b[N-1];
      default: op_msb = 1'b1;
    endcase

    if (op_sel == 2'b00 && !carry_in)
      AST_TRANSFER_A: assert (result == a && !carry_out); // R1
    if (op_sel == 2'b11 && carry_in)
      AST_ONES_PLUS_ONE: assert (result == a && carry_out); // R6
    if (op_sel == 2'b11 && !carry_in && a == '0)
      AST_DEC_WRAP: assert (result == '1 && !carry_out); // R5
    if (op_sel == 2'b10 && carry_in && a == b)
      AST_SUB_EQUAL: assert (result == '0 && carry_out); // R4
    if (overflow)
      AST_OVF_SIGN: assert (a[N-1] == op_msb && result[N-1] != a[N-1]); // R7
    if (op_sel == 2'b00 && carry_in)
      AST_INC_NO_OVF_UNLESS_MAX: assert (carry_out == (a == '1)); // R2
  end
endmodule

bind arith_unit arith_unit_chk #(.N(N)) u_chk (.*);

// File: tb/tb_arith_unit.sv
module tb_arith_unit;
  localparam int N = 8;
  localparam int WATCHDOG = 100000;

  logic clk;
  logic rst_n;
  logic [N-1:0] a, b;
  logic [1:0]   op_sel;
  logic         carry_in;
  logic [N-1:0] result;
  logic         carry_out;
  logic         overflow;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  arith_unit #(.N(N)) dut (
    .a(a), .b(b), .op_sel(op_sel), .carry_in(carry_in),
    .result(result), .carry_out(carry_out), .overflow(overflow)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic string tag_of(logic [1:0] s, logic c);
    case ({s, c})
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010, 3'b011: return "R3";
      3'b100, 3'b101: return "R4";
      3'b110: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic apply(input logic [N-1:0] ta, input logic [N-1:0] tb_,
                       input logic [1:0] ts, input logic tc);
    int unsigned yv, full, max_u;
    int sa, sy, ssum, exp_ovf;
    logic [N-1:0] exp_res;
    logic exp_c;
    @(posedge clk);
    #1;
    a = ta; b = tb_; op_sel = ts; carry_in = tc;
    max_u = (1 << N) - 1;
    case (ts)
      2'b00: yv = 0;
      2'b01: yv = int'(tb_);
      2'b10: yv = max_u - int'(tb_);
      default: yv = max_u;
    endcase
    full    = int'(ta) + yv + int'(tc);
    exp_res = full[N-1:0];
    exp_c   = full[N];
    sa = (int'(ta) >= (1 << (N-1))) ? int'(ta) - (1 << N) : int'(ta);
    sy = (int'(yv) >= (1 << (N-1))) ? int'(yv) - (1 << N) : int'(yv);
    ssum = sa + sy + int'(tc);
    exp_ovf = (ssum > (1 << (N-1)) - 1 || ssum < -(1 << (N-1))) ? 1 : 0;
    @(negedge clk);
    vectors++;
    // R8: outputs checked in the same cycle the inputs changed
    if (result !== exp_res || carry_out !== exp_c) begin
      fails++;
      $display("FAIL %s R8 a=%0h b=%0h sel=%b cin=%b: got res=%0h c=%b, expected res=%0h c=%b",
               tag_of(ts, tc), ta, tb_, ts, tc, result, carry_out, exp_res, exp_c);
    end
    if (overflow !== exp_ovf[0]) begin
      fails++;
      $display("FAIL R7 a=%0h b=%0h sel=%b cin=%b: got ovf=%b, expected ovf=%b",
               ta, tb_, ts, tc, overflow, exp_ovf[0]);
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: got running, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [N-1:0] corners [5];
    corners[0] = '0; corners[1] = 8'h01; corners[2] = 8'h7f;
    corners[3] = 8'h80; corners[4] = '1;
    a = '0; b = '0; op_sel = 2'b00; carry_in = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // idle inputs: zero result, no carry, no overflow (R1)
    @(negedge clk);
    vectors++;
    if (result !== '0 || carry_out !== 1'b0 || overflow !== 1'b0) begin
      fails++;
      $display("FAIL R1 idle: got %0h/%b/%b, expected 0/0/0", result, carry_out, overflow);
    end
    // directed cases per function
    apply(8'h5a, 8'h33, 2'b00, 1'b0); // R1 transfer
    apply(8'hff, 8'h00, 2'b00, 1'b1); // R2 increment wraps, carry set
    apply(8'h7f, 8'h00, 2'b00, 1'b1); // R2 and R7 positive overflow
    apply(8'hff, 8'h01, 2'b01, 1'b0); // R3 carry out
    apply(8'h40, 8'h40, 2'b01, 1'b0); // R3 and R7 overflow
    apply(8'h10, 8'h10, 2'b10, 1'b1); // R4 equal operands
    apply(8'h05, 8'h09, 2'b10, 1'b1); // R4 borrow, no carry
    apply(8'h80, 8'h01, 2'b10, 1'b1); // R4 and R7 negative overflow
    apply(8'h00, 8'h00, 2'b11, 1'b0); // R5 decrement zero
    apply(8'h80, 8'h00, 2'b11, 1'b0); // R5 and R7
    apply(8'h3c, 8'hc3, 2'b11, 1'b1); // R6 transfer with carry
    // corner sweep over all eight functions
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 2; c++)
        for (int i = 0; i < 5; i++)
          for (int j = 0; j < 5; j++)
            apply(corners[i], corners[j], 2'(s), 1'(c));
    // random operands
    for (int k = 0; k < 2000; k++)
      apply(N'($urandom), N'($urandom), 2'($urandom), 1'($urandom));
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule